// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an external I2C controller read and write a bank of 8-bit registers inside the chip. The SCL and SDA lines are brought into the system clock domain and watched for start and stop conditions. After a start, the block checks the first byte against its 7-bit target address. The upper four address bits are fixed at `0111`. Three strap inputs set the lower three bits, so one bus can carry up to eight of these targets.

A write transaction carries a sub-address byte, which loads an internal 8-bit pointer, and then any number of data bytes. Each data byte is acknowledged and produces a one-cycle strobe on the register bus. A read transaction sends the register that the pointer selects, most significant bit first. After every data byte, written or read, the pointer steps by one. A read burst continues until the controller leaves SDA high in the acknowledge slot. A repeated start keeps the pointer, so the usual sequence works: write the sub-address, send a repeated start, then read.

The block drives SDA only through an open-drain pull-low enable. The register file sits outside the block. It receives `reg_addr`, `reg_wdata` and `reg_wr_en`, and it returns `reg_rdata` combinationally for the address presented. The system clock is assumed to run at least 8 times faster than SCL.

Top module: `i2c_regport`

## Requirements
- R1: SDA falling while SCL is high is a start and begins address decoding. SDA rising while SCL is high is a stop and returns the block to idle with `sda_drive_low` at 0.
- R2: A first byte whose upper seven bits equal `0111` followed by `strap_addr[2:0]` (MSB first) is acknowledged: SDA is pulled low during the ninth SCL clock. Bit 0 of that byte selects read (1) or write (0).
- R3: On an address mismatch the block never pulls SDA low and issues no register writes until the next start.
- R4: In a write transaction, the second byte is acknowledged and loads the sub-address pointer.
- R5: Each later write byte is acknowledged. It produces exactly one system-clock cycle of `reg_wr_en`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, received MSB first.
- R6: The pointer (visible on `reg_addr`) rises by one after every data byte, written or read, and wraps from 0xFF to 0x00. A stop does not change it.
- R7: In a read transaction, the block sends the value of `reg_rdata` at the pointer, MSB first, and releases SDA during the acknowledge clock.
- R8: When the controller does not acknowledge a read byte, the block releases SDA. Further clocks do not make it drive SDA or move the pointer until a start or stop.
- R9: A repeated start returns the block to address decoding and keeps the pointer value.
- R10: `sda_drive_low` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_addr | input | 3 | Low three bits of the target address |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register address (sub-address pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
Two functions can land on the same SCL falling edge: the pointer increment for a finished read byte, and the loading of the next byte to transmit. The transmitted value must come from the already-advanced pointer. The bench provokes this with multi-byte read bursts across distinct register contents, and it judges every byte received against its own register model at the expected address. A second coincidence comes after a written byte: the write strobe and the pointer step follow one another. The bench checks that each byte lands at the pointer value in force before the step, including across the 0xFF to 0x00 wrap.

// File: rtl/i2c_regport_pkg.sv
// Shared constants and the transaction state type for the I2C register port.
package i2c_regport_pkg;

    localparam int DATA_W = 8;
    localparam logic [3:0] ADDR_FIXED_HI = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } port_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the system clock domain through a flop chain and
// flags SCL edges plus start and stop conditions on the synchronized levels.
// Assumes the system clock is at least 8x the SCL rate; lines idle high.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic            scl_prev;
    logic            sda_prev;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_in};
        end
    end

    // Decode edges and bus conditions from current and previous levels.
    always_comb begin
        scl_lvl   = scl_pipe[STAGES-1];
        sda_lvl   = sda_pipe[STAGES-1];
        scl_prev  = scl_pipe[STAGES];
        sda_prev  = sda_pipe[STAGES];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

    // R1: a start can only be flagged while SCL stays high
    p_start_scl_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |-> $past(scl_lvl));

endmodule

// File: rtl/i2c_subaddr_ptr.sv
// Sub-address pointer: loaded from the sub-address byte, stepped by one after
// each data byte, wrapping at the top of its range. Load wins over step.
module i2c_subaddr_ptr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] ptr
);

    // Hold, load or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= ptr + 1'b1;
    end

    // R6: a step moves the pointer by exactly one, wrapping at the top
    p_step_by_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> ptr == W'($past(ptr) + 1'b1));

    // R6: pointer is otherwise untouched
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(ptr));

endmodule

// File: rtl/i2c_regport.sv
// I2C target giving a bus controller access to an external 8-bit register
// bank. Decodes 0111+strap addresses, takes a sub-address, then writes or
// reads a burst with an auto-stepping pointer. Drives SDA only low, and only
// while SCL is low. reg_rdata must be valid combinationally for reg_addr.
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap_addr,
    output logic              sda_drive_low,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(DATA_W + 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    port_state_t         state;
    logic [CNT_W-1:0]    bitcnt;
    logic [DATA_W-1:0]   shreg;
    logic [DATA_W-2:0]   tx;
    logic                sda_oe;
    logic                rw_q;
    logic                nack_q;
    logic                wr_en_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                active;
    logic                ptr_load;
    logic                ptr_inc;
    logic [DATA_W-1:0]   ptr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Pointer control: load at sub-address end, step after write or read byte.
    always_comb begin
        active   = (state != ST_IDLE) && (state != ST_IGNORE);
        ptr_load = scl_fall && (bitcnt == BYTE_END) && (state == ST_SUB);
        ptr_inc  = wr_en_q ||
                   (scl_fall && (bitcnt == BYTE_END) && (state == ST_RDATA));
    end

    i2c_subaddr_ptr #(.W(DATA_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (shreg),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    // Bus transaction sequencer: bit counting, acknowledge and transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            sda_oe  <= 1'b0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            wr_en_q <= 1'b0;
            wdata_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (start_det) begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (scl_rise && active) begin
                if (bitcnt < BYTE_END)
                    shreg <= {shreg[DATA_W-2:0], sda_lvl};
                else
                    nack_q <= sda_lvl;
                bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && active) begin
                if (bitcnt == BYTE_END) begin
                    unique case (state)
                        ST_ADDR: begin
                            if (shreg[DATA_W-1:1] == {ADDR_FIXED_HI, strap_addr}) begin
                                sda_oe <= 1'b1;
                                rw_q   <= shreg[0];
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                        ST_SUB:   sda_oe <= 1'b1;
                        ST_WDATA: begin
                            sda_oe  <= 1'b1;
                            wr_en_q <= 1'b1;
                            wdata_q <= shreg;
                        end
                        default:  sda_oe <= 1'b0;
                    endcase
                end else if (bitcnt == ACK_END) begin
                    bitcnt <= '0;
                    unique case (state)
                        ST_ADDR: begin
                            if (rw_q) begin
                                state  <= ST_RDATA;
                                tx     <= reg_rdata[DATA_W-2:0];
                                sda_oe <= ~reg_rdata[DATA_W-1];
                            end else begin
                                state  <= ST_SUB;
                                sda_oe <= 1'b0;
                            end
                        end
                        ST_SUB: begin
                            state  <= ST_WDATA;
                            sda_oe <= 1'b0;
                        end
                        ST_RDATA: begin
                            if (nack_q) begin
                                state  <= ST_IGNORE;
                                sda_oe <= 1'b0;
                            end else begin
                                tx     <= reg_rdata[DATA_W-2:0];
                                sda_oe <= ~reg_rdata[DATA_W-1];
                            end
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (bitcnt != '0 && state == ST_RDATA) begin
                    sda_oe <= ~tx[DATA_W-2];
                    tx     <= {tx[DATA_W-3:0], 1'b0};
                end
            end
        end
    end

    assign sda_drive_low = sda_oe;
    assign reg_wr_en     = wr_en_q;
    assign reg_addr      = ptr;
    assign reg_wdata     = wdata_q;

    // R1: idle target never holds the data line
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_drive_low);

    // R3: a deselected target stays silent on the bus and the register bus
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_drive_low && !reg_wr_en));

    // R5: each write strobe lasts a single cycle
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R6: the write lands at the old pointer, which then steps by one
    p_step_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_addr == DATA_W'($past(reg_addr) + 1'b1));

    // R10: the SDA drive only moves while the synchronized SCL is low
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_lvl);

endmodule

// File: tb/i2c_regport_test.sv
// Directed bench: a bit-level bus controller model, an open-drain line and a
// register-bank model answering reg_addr combinationally.
module i2c_regport_test;

    localparam int Q = 10;  // quarter SCL period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_drive_low;
    logic       reg_wr_en;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire        sda_line = sda_m & ~sda_drive_low;

    logic [7:0] mem [256];
    int         wr_count = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    int         drive_viol = 0;
    logic       prev_drv = 1'b0;

    always #2.5 clk = ~clk;

    i2c_regport uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda_line),
        .strap_addr    (strap),
        .sda_drive_low (sda_drive_low),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    // Register-bank model, preset on reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (reg_wr_en) begin
            mem[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // R10 monitor: drive changes seen while the bus clock is high.
    always @(negedge clk) begin
        if (rst_n && sda_drive_low != prev_drv && scl) drive_viol++;
        prev_drv <= sda_drive_low;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input bit b, output bit s);
        wait_clk(Q); sda_m = b;
        wait_clk(Q); scl = 1'b1;
        wait_clk(Q); s = sda_line;
        wait_clk(Q); scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; wait_clk(2*Q);
        sda_m = 1'b0; wait_clk(2*Q);
        scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_clk(Q); sda_m = 1'b1;
        wait_clk(Q); scl = 1'b1;
        wait_clk(2*Q); sda_m = 1'b0;
        wait_clk(2*Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(Q); sda_m = 1'b0;
        wait_clk(Q); scl = 1'b1;
        wait_clk(2*Q); sda_m = 1'b1;
        wait_clk(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(!give_ack, s);
    endtask

    task automatic t_reset();
        chk(sda_drive_low == 1'b0, "R1", "reset drive", sda_drive_low, 0);
        chk(reg_wr_en == 1'b0, "R5", "reset strobe", reg_wr_en, 0);
        chk(reg_addr == 8'h00, "R6", "reset pointer", reg_addr, 0);
    endtask

    task automatic t_write_burst();
        bit a;
        int w0 = wr_count;
        bus_start();
        send_byte(8'h7A, a); chk(a, "R2", "addr 7A ack", a, 1);
        send_byte(8'h10, a); chk(a, "R4", "sub ack", a, 1);
        send_byte(8'hA5, a); chk(a, "R5", "data0 ack", a, 1);
        send_byte(8'h3C, a); chk(a, "R5", "data1 ack", a, 1);
        bus_stop();
        wait_clk(4);
        chk(mem[8'h10] == 8'hA5, "R5", "mem[10]", mem[8'h10], 8'hA5);
        chk(mem[8'h11] == 8'h3C, "R5", "mem[11]", mem[8'h11], 8'h3C);
        chk(wr_count - w0 == 2, "R5", "strobe count", wr_count - w0, 2);
        chk(reg_addr == 8'h12, "R6", "ptr after write", reg_addr, 8'h12);
        chk(sda_drive_low == 1'b0, "R1", "released after stop", sda_drive_low, 0);
    endtask

    task automatic t_read_rstart();
        bit a;
        logic [7:0] d;
        logic [7:0] exp12 = mem[8'h12];
        logic [7:0] exp13 = mem[8'h13];
        bus_start();
        send_byte(8'h7A, a); chk(a, "R2", "addr ack", a, 1);
        send_byte(8'h10, a); chk(a, "R4", "sub ack", a, 1);
        bus_rstart();
        send_byte(8'h7B, a); chk(a, "R9", "read addr after rstart ack", a, 1);
        recv_byte(1'b1, d); chk(d == 8'hA5, "R7", "read byte0", d, 8'hA5);
        recv_byte(1'b1, d); chk(d == 8'h3C, "R7", "read byte1", d, 8'h3C);
        recv_byte(1'b0, d); chk(d == exp12, "R7", "read byte2", d, exp12);
        chk(reg_addr == 8'h13, "R6", "ptr after nacked read", reg_addr, 8'h13);
        recv_byte(1'b1, d); chk(d == 8'hFF, "R8", "bus released after nack", d, 8'hFF);
        chk(reg_addr == 8'h13, "R8", "ptr frozen after nack", reg_addr, 8'h13);
        bus_stop();
        chk(reg_addr == 8'h13, "R6", "ptr kept over stop", reg_addr, 8'h13);
        bus_start();
        send_byte(8'h7B, a); chk(a, "R2", "read addr ack", a, 1);
        recv_byte(1'b0, d); chk(d == exp13, "R6", "read continues at pointer", d, exp13);
        bus_stop();
    endtask

    task automatic t_wrap();
        bit a;
        bus_start();
        send_byte(8'h7A, a);
        send_byte(8'hFF, a); chk(a, "R4", "sub FF ack", a, 1);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop();
        wait_clk(4);
        chk(mem[8'hFF] == 8'h11, "R6", "mem[FF]", mem[8'hFF], 8'h11);
        chk(mem[8'h00] == 8'h22, "R6", "wrap mem[00]", mem[8'h00], 8'h22);
        chk(reg_addr == 8'h01, "R6", "ptr after wrap", reg_addr, 8'h01);
    endtask

    task automatic t_mismatch();
        bit a;
        int w0 = wr_count;
        bus_start();
        send_byte(8'h72, a); chk(!a, "R3", "foreign addr no ack", a, 0);
        send_byte(8'h05, a); chk(!a, "R3", "later byte no ack", a, 0);
        send_byte(8'h99, a); chk(!a, "R3", "later byte no ack", a, 0);
        bus_stop();
        wait_clk(4);
        chk(wr_count == w0, "R3", "no writes", wr_count - w0, 0);
        chk(reg_addr == 8'h01, "R3", "ptr untouched", reg_addr, 8'h01);
    endtask

    task automatic t_strap();
        bit a;
        strap = 3'b000;
        wait_clk(4);
        bus_start();
        send_byte(8'h7A, a); chk(!a, "R2", "old strap addr no ack", a, 0);
        bus_rstart();
        send_byte(8'h70, a); chk(a, "R2", "strap 000 addr ack", a, 1);
        send_byte(8'h40, a);
        send_byte(8'h77, a); chk(a, "R5", "data ack", a, 1);
        bus_stop();
        wait_clk(4);
        chk(mem[8'h40] == 8'h77, "R5", "mem[40]", mem[8'h40], 8'h77);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_burst();
        t_read_rstart();
        t_wrap();
        t_mismatch();
        t_strap();
        chk(drive_viol == 0, "R10", "drive changes with SCL high", drive_viol, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule